// File: doc/BRIEF.md
# Mailbox Write Guard with Data-Change Handshake

This block sits between a simple CPU register bus and a bank of message mailboxes. It decides whether each CPU write to a mailbox's identifier field or data field may reach the mailbox storage. It also keeps the per-mailbox control bits that the decision depends on: enable, direction, transmit request and transmit-reset request. A single global data-change flag lets the CPU update a transmit mailbox that is waiting to be sent. When the guard refuses a write to a transmit mailbox that is waiting to be sent, it latches a write-denied interrupt.

The transmit scheduler asks the guard to check the data-change flag twice for each mailbox it reads: once before the read (pre-check) and once after (post-check). For each check, the guard returns either a one-cycle abort pulse, which carries the mailbox index, or a one-cycle go pulse. An abort tells the scheduler to skip that mailbox and move on to other pending requests. The storage itself and the scheduler are outside this block. The guard emits a registered write strobe, with the index, field and data, only for writes it accepts.

All results appear on registered outputs one clock after the request. Every check reads the state held before that clock edge. A control write made in the same cycle as a check therefore takes effect for the next cycle.

Top module: `mbx_access_guard`

## Requirements
- R1: A write with field code 0 (identifier) is accepted only when the addressed mailbox's enable bit is 0. Control select code 0 sets the enable bit.
- R2: A write with field code 1 (data) to a mailbox whose direction bit is 0 (receive) is always refused, whatever the data-change flag, and it raises no interrupt. Control select code 1 sets the direction bit, where 1 means transmit.
- R3: A data write to a transmit mailbox is refused when its transmit-request bit (select 2) or its transmit-reset bit (select 3) is 1 and the data-change flag is 0. With both bits at 0 the write is accepted.
- R4: While the data-change flag is 1, data writes to transmit mailboxes are accepted even when their request bits are set.
- R5: A refused transmit data write sets a latched write-denied flag. The flag stays set until the CPU writes 1 to the clear input. If a new refusal arrives in the same cycle as a clear, the flag stays set.
- R6: The interrupt output is 0 while the data-change flag is 1. A latched flag shows again once the CPU clears the data-change flag.
- R7: The CPU sets the data-change flag by writing 1 and clears it by writing 0. Decisions made in the same cycle as that write use the old value.
- R8: A pre-check (stage 0) that finds the data-change flag at 1 produces a one-cycle abort pulse carrying the checked index. A pre-check that finds the flag at 0 produces no output pulse.
- R9: A post-check (stage 1) for the index of the most recent unmatched pre-check gives a go pulse only if the flag was 0 at both checks. Otherwise it gives an abort pulse carrying that index. Abort and go never occur together.
- R10: A post-check with no matching pending pre-check aborts.
- R11: An accepted write drives the write strobe one cycle later, with the same index, field and data. A refused write leaves the strobe at 0.
- R12: After reset, all control bits and both flags are 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cfg_we | input | 1 | Control-bit write strobe |
| cpu_cfg_idx | input | IDX_W | Mailbox for the control write |
| cpu_cfg_sel | input | 2 | 0 enable, 1 direction, 2 transmit request, 3 transmit reset |
| cpu_cfg_val | input | 1 | New control-bit value |
| cpu_dchg_we | input | 1 | Data-change flag write strobe |
| cpu_dchg_val | input | 1 | New data-change flag value |
| cpu_wdi_clr | input | 1 | Write 1 to clear the write-denied flag |
| cpu_mb_we | input | 1 | Mailbox field write request |
| cpu_mb_idx | input | IDX_W | Target mailbox |
| cpu_mb_field | input | 1 | 0 identifier, 1 data |
| cpu_mb_wdata | input | DATA_W | Write data |
| sch_chk | input | 1 | Scheduler flag-check request |
| sch_post | input | 1 | 0 pre-check, 1 post-check |
| sch_idx | input | IDX_W | Mailbox being read by the scheduler |
| ram_we | output | 1 | Accepted write strobe to the storage |
| ram_idx | output | IDX_W | Mailbox of the accepted write |
| ram_field | output | 1 | Field of the accepted write |
| ram_wdata | output | DATA_W | Data of the accepted write |
| wdi_irq | output | 1 | Write-denied interrupt |
| sch_abort | output | 1 | Skip-this-mailbox pulse |
| sch_abort_idx | output | IDX_W | Index of the aborted mailbox |
| sch_go | output | 1 | Transmission may proceed |

## Verification
Two functions can fall in the same cycle. The first is a CPU write to the data-change flag. The second is either a data write to a guarded transmit mailbox or a scheduler check. The bench provokes this collision with directed cycles and with random stimulus in which the flag toggles often. In each such cycle, the bench expects the write decision and the check result to follow the flag's old value. It judges the flag's new value only from the following cycle. The bench also pairs a refusal with an interrupt clear in one cycle and expects the latched flag to survive.

// File: rtl/mbx_guard_pkg.sv
package mbx_guard_pkg;
  typedef enum logic {FLD_ID = 1'b0, FLD_DATA = 1'b1} mb_field_e;
  typedef enum logic [1:0] {
    CFG_EN    = 2'd0,
    CFG_DIR   = 2'd1,
    CFG_TXREQ = 2'd2,
    CFG_TXRST = 2'd3
  } cfg_sel_e;
  typedef struct packed {
    logic en;
    logic tx;
    logic txreq;
    logic txrst;
  } mbx_bits_t;
endpackage

// File: rtl/mbx_bit_bank.sv
module mbx_bit_bank
  import mbx_guard_pkg::*;
#(
  parameter int NUM_MBX = 32,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  cfg_sel_e         cfg_sel,
  input  logic             cfg_val,
  input  logic [IDX_W-1:0] rd_idx,
  output mbx_bits_t        rd_bits
);
  mbx_bits_t bank [NUM_MBX];

  for (genvar g = 0; g < NUM_MBX; g++) begin : g_mbx
    mbx_bits_t bits_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bits_q <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
        unique case (cfg_sel)
          CFG_EN:    bits_q.en    <= cfg_val;
          CFG_DIR:   bits_q.tx    <= cfg_val;
          CFG_TXREQ: bits_q.txreq <= cfg_val;
          CFG_TXRST: bits_q.txrst <= cfg_val;
          default:   bits_q       <= bits_q;
        endcase
      end
    end
    assign bank[g] = bits_q;
  end

  assign rd_bits = bank[rd_idx];
endmodule

// File: rtl/mbx_write_judge.sv
module mbx_write_judge
  import mbx_guard_pkg::*;
(
  input  logic      mb_we,
  input  mb_field_e field,
  input  mbx_bits_t bits,
  input  logic      dchg,
  output logic      allow,
  output logic      deny_irq
);
  always_comb begin
    allow    = 1'b0;
    deny_irq = 1'b0;
    if (mb_we) begin
      if (field == FLD_ID) begin
        allow = !bits.en;
      end else if (!bits.tx) begin
        allow = 1'b0;
      end else if ((bits.txreq || bits.txrst) && !dchg) begin
        deny_irq = 1'b1;
      end else begin
        allow = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbx_sched_check.sv
module mbx_sched_check #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk,
  input  logic             post,
  input  logic [IDX_W-1:0] idx,
  input  logic             dchg,
  output logic             abort,
  output logic [IDX_W-1:0] abort_idx,
  output logic             go
);
  logic             armed_q;
  logic             dirty_q;
  logic [IDX_W-1:0] armed_idx_q;
  logic             matched;

  assign matched = armed_q && (armed_idx_q == idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q     <= 1'b0;
      dirty_q     <= 1'b0;
      armed_idx_q <= '0;
      abort       <= 1'b0;
      abort_idx   <= '0;
      go          <= 1'b0;
    end else begin
      abort <= 1'b0;
      go    <= 1'b0;
      if (chk && !post) begin
        armed_q     <= 1'b1;
        armed_idx_q <= idx;
        dirty_q     <= dchg;
        if (dchg) begin
          abort     <= 1'b1;
          abort_idx <= idx;
        end
      end else if (chk && post) begin
        armed_q <= 1'b0;
        if (!matched || dirty_q || dchg) begin
          abort     <= 1'b1;
          abort_idx <= idx;
        end else begin
          go <= 1'b1;
        end
      end
    end
  end

  assert_abort_go_excl_R9 : assert property (@(posedge clk) disable iff (rst)
    $onehot0({abort, go}));

  assert_unmatched_post_aborts_R10 : assert property (@(posedge clk) disable iff (rst)
    (chk && post && !armed_q) |=> (abort && !go));
endmodule

// File: rtl/mbx_access_guard.sv
module mbx_access_guard
  import mbx_guard_pkg::*;
#(
  parameter int NUM_MBX = 32,
  parameter int DATA_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_cfg_we,
  input  logic [$clog2(NUM_MBX)-1:0] cpu_cfg_idx,
  input  logic [1:0]                 cpu_cfg_sel,
  input  logic                       cpu_cfg_val,
  input  logic                       cpu_dchg_we,
  input  logic                       cpu_dchg_val,
  input  logic                       cpu_wdi_clr,
  input  logic                       cpu_mb_we,
  input  logic [$clog2(NUM_MBX)-1:0] cpu_mb_idx,
  input  logic                       cpu_mb_field,
  input  logic [DATA_W-1:0]          cpu_mb_wdata,
  input  logic                       sch_chk,
  input  logic                       sch_post,
  input  logic [$clog2(NUM_MBX)-1:0] sch_idx,
  output logic                       ram_we,
  output logic [$clog2(NUM_MBX)-1:0] ram_idx,
  output logic                       ram_field,
  output logic [DATA_W-1:0]          ram_wdata,
  output logic                       wdi_irq,
  output logic                       sch_abort,
  output logic [$clog2(NUM_MBX)-1:0] sch_abort_idx,
  output logic                       sch_go
);
  localparam int IDX_W = $clog2(NUM_MBX);

  mbx_bits_t cur_bits;
  logic      dchg_q;
  logic      dchg_next;
  logic      wdi_q;
  logic      wdi_next;
  logic      allow;
  logic      deny_irq;

  mbx_bit_bank #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cpu_cfg_we),
    .cfg_idx (cpu_cfg_idx),
    .cfg_sel (cfg_sel_e'(cpu_cfg_sel)),
    .cfg_val (cpu_cfg_val),
    .rd_idx  (cpu_mb_idx),
    .rd_bits (cur_bits)
  );

  mbx_write_judge u_judge (
    .mb_we    (cpu_mb_we),
    .field    (mb_field_e'(cpu_mb_field)),
    .bits     (cur_bits),
    .dchg     (dchg_q),
    .allow    (allow),
    .deny_irq (deny_irq)
  );

  mbx_sched_check #(.IDX_W(IDX_W)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .chk       (sch_chk),
    .post      (sch_post),
    .idx       (sch_idx),
    .dchg      (dchg_q),
    .abort     (sch_abort),
    .abort_idx (sch_abort_idx),
    .go        (sch_go)
  );

  assign dchg_next = cpu_dchg_we ? cpu_dchg_val : dchg_q;
  assign wdi_next  = (wdi_q && !cpu_wdi_clr) || deny_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      dchg_q    <= 1'b0;
      wdi_q     <= 1'b0;
      wdi_irq   <= 1'b0;
      ram_we    <= 1'b0;
      ram_idx   <= '0;
      ram_field <= 1'b0;
      ram_wdata <= '0;
    end else begin
      dchg_q  <= dchg_next;
      wdi_q   <= wdi_next;
      wdi_irq <= wdi_next && !dchg_next;
      ram_we  <= allow;
      if (allow) begin
        ram_idx   <= cpu_mb_idx;
        ram_field <= cpu_mb_field;
        ram_wdata <= cpu_mb_wdata;
      end
    end
  end

  assert_id_locked_R1 : assert property (@(posedge clk) disable iff (rst)
    (cpu_mb_we && !cpu_mb_field && cur_bits.en) |=> !ram_we);

  assert_rx_data_refused_R2 : assert property (@(posedge clk) disable iff (rst)
    (cpu_mb_we && cpu_mb_field && !cur_bits.tx) |=> !ram_we);

  assert_wdi_latched_R5 : assert property (@(posedge clk) disable iff (rst)
    (wdi_q && !cpu_wdi_clr) |=> wdi_q);

  assert_irq_masked_R6 : assert property (@(posedge clk) disable iff (rst)
    dchg_q |-> !wdi_irq);

  assert_dchg_opens_R4 : assert property (@(posedge clk) disable iff (rst)
    (cpu_mb_we && cpu_mb_field && cur_bits.tx && dchg_q) |=> ram_we);
endmodule

// File: tb/mbx_access_guard_bench.sv
`timescale 1ns/1ps
module mbx_access_guard_bench;
  localparam int NUM_MBX = 32;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = $clog2(NUM_MBX);

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;

  logic              cfg_we, cfg_val, dchg_we, dchg_val, wdi_clr;
  logic [IDX_W-1:0]  cfg_idx, mb_idx, s_idx;
  logic [1:0]        cfg_sel;
  logic              mb_we, mb_field, s_chk, s_post;
  logic [DATA_W-1:0] mb_wdata;
  logic              ram_we, ram_field, wdi_irq, sch_abort, sch_go;
  logic [IDX_W-1:0]  ram_idx, sch_abort_idx;
  logic [DATA_W-1:0] ram_wdata;

  mbx_access_guard #(.NUM_MBX(NUM_MBX), .DATA_W(DATA_W)) u_mbx_access_guard (
    .clk(clk), .rst(rst),
    .cpu_cfg_we(cfg_we), .cpu_cfg_idx(cfg_idx), .cpu_cfg_sel(cfg_sel), .cpu_cfg_val(cfg_val),
    .cpu_dchg_we(dchg_we), .cpu_dchg_val(dchg_val), .cpu_wdi_clr(wdi_clr),
    .cpu_mb_we(mb_we), .cpu_mb_idx(mb_idx), .cpu_mb_field(mb_field), .cpu_mb_wdata(mb_wdata),
    .sch_chk(s_chk), .sch_post(s_post), .sch_idx(s_idx),
    .ram_we(ram_we), .ram_idx(ram_idx), .ram_field(ram_field), .ram_wdata(ram_wdata),
    .wdi_irq(wdi_irq), .sch_abort(sch_abort), .sch_abort_idx(sch_abort_idx), .sch_go(sch_go)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic m_en [NUM_MBX];
  logic m_tx [NUM_MBX];
  logic m_rq [NUM_MBX];
  logic m_rs [NUM_MBX];
  logic m_dchg, m_wdi, m_armed, m_dirty;
  logic [IDX_W-1:0] m_aidx;

  task automatic chk(input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_idx = '0; cfg_sel = '0; cfg_val = 0;
    dchg_we = 0; dchg_val = 0; wdi_clr = 0;
    mb_we = 0; mb_idx = '0; mb_field = 0; mb_wdata = '0;
    s_chk = 0; s_post = 0; s_idx = '0;
  endtask

  function automatic string write_tag();
    if (!mb_field) return "R1";
    if (!m_tx[mb_idx]) return "R2";
    if (dchg_we && m_dchg) return "R7";
    if (m_dchg) return "R4";
    return "R3";
  endfunction

  // One clock: predict from the model, take the edge, compare, update the model.
  task automatic tick();
    logic allow, deny, wdi_n, dchg_n, e_abort, e_go, matched;
    allow = 0; deny = 0;
    if (mb_we) begin
      if (!mb_field) allow = !m_en[mb_idx];
      else if (!m_tx[mb_idx]) allow = 0;
      else if ((m_rq[mb_idx] || m_rs[mb_idx]) && !m_dchg) deny = 1;
      else allow = 1;
    end
    wdi_n  = (m_wdi && !wdi_clr) || deny;
    dchg_n = dchg_we ? dchg_val : m_dchg;
    matched = m_armed && (m_aidx == s_idx);
    e_abort = 0; e_go = 0;
    if (s_chk && !s_post) e_abort = m_dchg;
    else if (s_chk) begin
      e_abort = !matched || m_dirty || m_dchg;
      e_go = !e_abort;
    end
    @(posedge clk); #1;
    chk(ram_we, allow, write_tag());
    if (allow) begin
      chk(ram_idx, mb_idx, "R11 idx");
      chk(ram_field, mb_field, "R11 field");
      chk(ram_wdata, mb_wdata, "R11 data");
    end
    chk(wdi_irq, wdi_n && !dchg_n, dchg_n ? "R6" : "R5");
    chk(sch_abort, e_abort, (s_chk && s_post && !matched) ? "R10" : (s_post ? "R9" : "R8"));
    chk(sch_go, e_go, "R9 go");
    if (e_abort) chk(sch_abort_idx, s_idx, "R8 abort idx");
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: m_en[cfg_idx] = cfg_val;
        2'd1: m_tx[cfg_idx] = cfg_val;
        2'd2: m_rq[cfg_idx] = cfg_val;
        default: m_rs[cfg_idx] = cfg_val;
      endcase
    end
    if (s_chk && !s_post) begin m_armed = 1; m_aidx = s_idx; m_dirty = m_dchg; end
    else if (s_chk) m_armed = 0;
    m_wdi = wdi_n;
    m_dchg = dchg_n;
    idle();
  endtask

  task automatic set_bit(input int idx, input int sel, input logic v);
    cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_sel = 2'(sel); cfg_val = v; tick();
  endtask

  task automatic mbw(input int idx, input logic fld, input logic [DATA_W-1:0] d);
    mb_we = 1; mb_idx = IDX_W'(idx); mb_field = fld; mb_wdata = d;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    for (int i = 0; i < NUM_MBX; i++) begin
      m_en[i] = 0; m_tx[i] = 0; m_rq[i] = 0; m_rs[i] = 0;
    end
    m_dchg = 0; m_wdi = 0; m_armed = 0; m_dirty = 0; m_aidx = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    // R12: reset state at the outputs
    chk(ram_we, 0, "R12 ram_we");
    chk(wdi_irq, 0, "R12 wdi_irq");
    chk(sch_abort, 0, "R12 sch_abort");
    chk(sch_go, 0, "R12 sch_go");

    // R1: identifier write open, then locked by enable
    mbw(3, 0, 32'hA5A5_0001); tick();
    set_bit(3, 0, 1);
    mbw(3, 0, 32'hA5A5_0002); tick();
    // R2: receive data refused, even with the data-change flag
    mbw(4, 1, 32'h1111); tick();
    dchg_we = 1; dchg_val = 1; tick();
    mbw(4, 1, 32'h2222); tick();
    dchg_we = 1; dchg_val = 0; tick();
    // R3: transmit mailbox, idle then requested
    set_bit(5, 1, 1);
    mbw(5, 1, 32'h3333); tick();
    set_bit(5, 2, 1);
    mbw(5, 1, 32'h4444); tick();                          // refused, R5 flag set
    wdi_clr = 1; mbw(5, 1, 32'h4445); tick();             // R5 refusal beats clear
    wdi_clr = 1; tick();
    set_bit(5, 2, 0); set_bit(5, 3, 1);
    // R7: flag set in the same cycle as the write still refuses
    dchg_we = 1; dchg_val = 1; mbw(5, 1, 32'h5555); tick();
    // R4 and R6: flag open, interrupt masked
    mbw(5, 1, 32'h6666); tick();
    dchg_we = 1; dchg_val = 0; tick();                    // R6 latched flag reappears
    wdi_clr = 1; tick();
    // R8/R9: clean pair, dirty pre, dirty post, R10 unmatched
    s_chk = 1; s_post = 0; s_idx = 5'd7; tick();
    s_chk = 1; s_post = 1; s_idx = 5'd7; tick();
    dchg_we = 1; dchg_val = 1; s_chk = 1; s_post = 0; s_idx = 5'd8; tick();   // old value 0
    dchg_we = 1; dchg_val = 0; s_chk = 1; s_post = 1; s_idx = 5'd8; tick();   // flag 1 now
    s_chk = 1; s_post = 1; s_idx = 5'd8; tick();          // R10 nothing pending
    s_chk = 1; s_post = 0; s_idx = 5'd9; tick();
    s_chk = 1; s_post = 1; s_idx = 5'd10; tick();         // R10 wrong index

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [IDX_W-1:0] last_pre;
      last_pre = m_aidx;
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1; cfg_idx = IDX_W'($urandom_range(0, 7));
        cfg_sel = 2'($urandom_range(0, 3)); cfg_val = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 9) == 0) begin dchg_we = 1; dchg_val = 1'($urandom_range(0, 1)); end
      wdi_clr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 1) == 0)
        mbw($urandom_range(0, 7), 1'($urandom_range(0, 1)), $urandom());
      if ($urandom_range(0, 2) == 0) begin
        s_chk = 1; s_post = 1'($urandom_range(0, 1));
        s_idx = ($urandom_range(0, 3) != 0) ? last_pre : IDX_W'($urandom_range(0, 7));
      end
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule